// File: doc/BRIEF.md
# Set/Clear Interrupt Status Aggregator

This block gathers the interrupt sources of a device into one status word. Bits are raised in two ways. Hardware events pulse strobes, and each strobe carries a bit mask. Software raises or drops bits through writes on a simple register bus. Software can also read the whole word back through that bus.

The block reports the pending state to the host in one of two ways. When `msi_enable` is low, it drives a level-sensitive interrupt line. When `msi_enable` is high, it sends a one-cycle notification pulse. In message mode, every raise event that leaves the word nonzero sends a new pulse, even if no new bit appears. In level mode, the line stays high until every bit has been cleared.

By convention, hardware source 0 carries mask `0x1` (computation done) and source 1 carries mask `0x100` (transfer done). The masks are inputs, so the integrator can choose other values.

Top module: `isa_aggregator`

## Requirements
- R1: After reset, the status word is 0, `irq_level` is 0 and `msi_pulse` is 0.
- R2: A read (`bus_valid`=1, `bus_write`=0) at offset 0x24 with `bus_size`=4 returns the status word on `rd_data` in the same cycle. Any other read returns 0xFFFFFFFF.
- R3: A 4-byte write at offset 0x60 ORs `bus_wdata` into the status word at the next clock edge.
- R4: A 4-byte write at offset 0x64 sets the status word to status AND NOT `bus_wdata` at the next clock edge.
- R5: A write whose `bus_size` is not 4 leaves the status word unchanged.
- R6: When strobe `hw_raise[i]` is high, mask slice i of `hw_mask` (bits `i*32` upward) is ORed into the status word at the next edge. Several strobes can be high in the same cycle.
- R7: When a hardware raise and a software clear hit the same bit in one cycle, the bit ends up set.
- R8: In level mode (`msi_enable`=0), `irq_level` goes high one edge after a raise event that leaves the status word nonzero. It stays high while any bit is pending, and it drops at the edge where a clear makes the word zero.
- R9: In message mode (`msi_enable`=1), `msi_pulse` is high for exactly one cycle after each raise event that leaves the status word nonzero. A set write of 0 counts as a raise event. A raise event that leaves the word zero sends no pulse. A clear sends no pulse.
- R10: While `msi_enable` is high, `irq_level` is low. If message mode is turned off while bits are pending, the line stays low until the next raise event, and it goes high one edge after that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_valid | input | 1 | Register access valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data (combinational) |
| hw_raise | input | 2 | Hardware raise strobes, one per source |
| hw_mask | input | 64 | Packed raise masks, 32 bits per source |
| msi_enable | input | 1 | Selects message mode (1) or level mode (0) |
| irq_level | output | 1 | Level-sensitive interrupt line |
| msi_pulse | output | 1 | One-cycle message notification |

## Verification
Read data is combinational, so the bench samples it 1 ns after it applies the read, with no clock edge in between. The status word, `irq_level` and `msi_pulse` all come from registers that load at the edge following the stimulus. The bench applies each stimulus on a falling edge and samples these outputs on the following falling edge. That is the single cycle in which a message pulse is visible. The bench then checks one falling edge later that the pulse has gone away.

// File: rtl/isa_pkg.sv
package isa_pkg;
  typedef enum logic [1:0] {
    ISA_OP_NONE = 2'd0,
    ISA_OP_SET  = 2'd1,
    ISA_OP_CLR  = 2'd2
  } isa_op_e;
endpackage

// File: rtl/isa_decode.sv
module isa_decode
  import isa_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SIZE_W   = 4,
  parameter int unsigned OK_SIZE  = 4,
  parameter int unsigned STAT_OFS = 'h24,
  parameter int unsigned SET_OFS  = 'h60,
  parameter int unsigned CLR_OFS  = 'h64
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SIZE_W-1:0] bus_size,
  output isa_op_e           op,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFS);
  localparam logic [SIZE_W-1:0] SZ_OK  = SIZE_W'(OK_SIZE);

  logic size_ok;
  logic wr_ok;

  always_comb begin
    size_ok = (bus_size == SZ_OK);
    wr_ok   = bus_valid && bus_write && size_ok;
    rd_hit  = bus_valid && !bus_write && size_ok && (bus_addr == STAT_A);
    if (wr_ok && (bus_addr == SET_A)) begin
      op = ISA_OP_SET;
    end else if (wr_ok && (bus_addr == CLR_A)) begin
      op = ISA_OP_CLR;
    end else begin
      op = ISA_OP_NONE;
    end
  end
endmodule

// File: rtl/isa_status_reg.sv
module isa_status_reg
  import isa_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_HW   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  isa_op_e                op,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [N_HW-1:0]        hw_raise,
  input  logic [N_HW*DATA_W-1:0] hw_mask,
  output logic [DATA_W-1:0]      status_q,
  output logic                   raise_evt,
  output logic                   next_nz
);
  logic [N_HW:0][DATA_W-1:0] hw_acc;
  logic [DATA_W-1:0]         set_vec;
  logic [DATA_W-1:0]         clr_vec;
  logic [DATA_W-1:0]         status_d;
  logic                      status_en;

  assign hw_acc[0] = '0;
  for (genvar g = 0; g < N_HW; g++) begin : g_src
    assign hw_acc[g+1] = hw_acc[g] |
                         (hw_raise[g] ? hw_mask[g*DATA_W +: DATA_W] : '0);
  end

  always_comb begin
    set_vec   = (op == ISA_OP_SET) ? wdata : '0;
    clr_vec   = (op == ISA_OP_CLR) ? wdata : '0;
    // raises are ORed after the clear, so a raise beats a clear on the same bit
    status_d  = (status_q & ~clr_vec) | set_vec | hw_acc[N_HW];
    raise_evt = (op == ISA_OP_SET) || (|hw_raise);
    status_en = (op != ISA_OP_NONE) || (|hw_raise);
    next_nz   = |status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end
endmodule

// File: rtl/isa_notify.sv
module isa_notify (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_evt,
  input  logic next_nz,
  input  logic msi_enable,
  output logic irq_level,
  output logic msi_pulse
);
  logic level_d;
  logic pulse_d;

  always_comb begin
    pulse_d = msi_enable && raise_evt && next_nz;
    if (msi_enable) begin
      level_d = 1'b0;
    end else if (raise_evt && next_nz) begin
      level_d = 1'b1;
    end else if (!next_nz) begin
      level_d = 1'b0;
    end else begin
      level_d = irq_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= 1'b0;
      msi_pulse <= 1'b0;
    end else begin
      irq_level <= level_d;
      msi_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/isa_aggregator.sv
module isa_aggregator
  import isa_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SIZE_W   = 4,
  parameter int unsigned OK_SIZE  = 4,
  parameter int unsigned N_HW     = 2,
  parameter int unsigned STAT_OFS = 'h24,
  parameter int unsigned SET_OFS  = 'h60,
  parameter int unsigned CLR_OFS  = 'h64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [SIZE_W-1:0]      bus_size,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      rd_data,
  input  logic [N_HW-1:0]        hw_raise,
  input  logic [N_HW*DATA_W-1:0] hw_mask,
  input  logic                   msi_enable,
  output logic                   irq_level,
  output logic                   msi_pulse
);
  isa_op_e           op;
  logic              rd_hit;
  logic [DATA_W-1:0] status_q;
  logic              raise_evt;
  logic              next_nz;

  isa_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OK_SIZE(OK_SIZE),
    .STAT_OFS(STAT_OFS), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
  ) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .op(op), .rd_hit(rd_hit)
  );

  isa_status_reg #(.DATA_W(DATA_W), .N_HW(N_HW)) u_stat (
    .clk(clk), .rst_n(rst_n), .op(op), .wdata(bus_wdata),
    .hw_raise(hw_raise), .hw_mask(hw_mask), .status_q(status_q),
    .raise_evt(raise_evt), .next_nz(next_nz)
  );

  isa_notify u_ntf (
    .clk(clk), .rst_n(rst_n), .raise_evt(raise_evt), .next_nz(next_nz),
    .msi_enable(msi_enable), .irq_level(irq_level), .msi_pulse(msi_pulse)
  );

  assign rd_data = rd_hit ? status_q : '1;
endmodule

// File: rtl/isa_aggregator_chk.sv
module isa_aggregator_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned SIZE_W  = 4,
  parameter int unsigned OK_SIZE = 4,
  parameter int unsigned N_HW    = 2,
  parameter int unsigned SET_OFS = 'h60,
  parameter int unsigned CLR_OFS = 'h64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SIZE_W-1:0] bus_size,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_HW-1:0]   hw_raise,
  input logic              msi_enable,
  input logic              irq_level,
  input logic              msi_pulse,
  input logic [DATA_W-1:0] status
);
  localparam logic [SIZE_W-1:0] SZ_OK = SIZE_W'(OK_SIZE);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

  p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_size == SZ_OK && bus_addr == SET_A)
    |=> ((status & $past(bus_wdata)) == $past(bus_wdata)));

  p_clear_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_size == SZ_OK && bus_addr == CLR_A && hw_raise == '0)
    |=> ((status & $past(bus_wdata)) == '0));

  p_bad_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_size != SZ_OK && hw_raise == '0)
    |=> $stable(status));

  p_level_needs_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level |-> (status != '0));

  p_pulse_needs_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> (status != '0));

  p_no_pulse_level_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_enable |=> !msi_pulse);

  p_level_low_msg_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msi_enable |=> !irq_level);
endmodule

bind isa_aggregator isa_aggregator_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OK_SIZE(OK_SIZE),
  .N_HW(N_HW), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
  .hw_raise(hw_raise), .msi_enable(msi_enable), .irq_level(irq_level),
  .msi_pulse(msi_pulse), .status(status_q)
);

// File: tb/isa_aggregator_tb.sv
module isa_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] rd_data;
  logic [1:0]  hw_raise;
  logic [63:0] hw_mask;
  logic        msi_enable;
  logic        irq_level;
  logic        msi_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  logic seen_pulse;
  logic seen_level;

  localparam logic [7:0] A_STAT = 8'h24;
  localparam logic [7:0] A_SET  = 8'h60;
  localparam logic [7:0] A_CLR  = 8'h64;

  always #10 clk = ~clk;

  isa_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .hw_raise(hw_raise), .hw_mask(hw_mask),
    .msi_enable(msi_enable), .irq_level(irq_level), .msi_pulse(msi_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle, applied at a falling edge; outputs sampled at the next one
  task automatic cyc(input logic v, input logic [7:0] a, input logic [3:0] sz,
                     input logic [31:0] d, input logic [1:0] hw);
    bus_valid = v; bus_write = v; bus_addr = a; bus_size = sz;
    bus_wdata = d; hw_raise = hw;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; hw_raise = 2'b00;
    seen_pulse = msi_pulse;
    seen_level = irq_level;
  endtask

  task automatic rd(input logic [3:0] sz, output logic [31:0] v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = A_STAT; bus_size = sz;
    #1;
    v = rd_data;
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd4, v);
    check("R1 status after reset", v, 32'h0);
    check("R1 level after reset", {31'b0, irq_level}, 32'h0);
    check("R1 pulse after reset", {31'b0, msi_pulse}, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    cyc(1'b1, A_SET, 4'd4, 32'h5, 2'b00);
    check("R8 level after set", {31'b0, seen_level}, 32'h1);
    rd(4'd4, v);
    check("R3 set 0x5", v, 32'h5);
    cyc(1'b1, A_SET, 4'd4, 32'h30, 2'b00);
    rd(4'd4, v);
    check("R3 set accumulates", v, 32'h35);
    cyc(1'b1, A_CLR, 4'd4, 32'h1, 2'b00);
    rd(4'd4, v);
    check("R4 partial clear", v, 32'h34);
    check("R8 level held on partial clear", {31'b0, seen_level}, 32'h1);
    cyc(1'b1, A_CLR, 4'd4, 32'h34, 2'b00);
    rd(4'd4, v);
    check("R4 full clear", v, 32'h0);
    check("R8 level drops at zero", {31'b0, seen_level}, 32'h0);
  endtask

  task automatic t_size();
    logic [31:0] v;
    cyc(1'b1, A_SET, 4'd2, 32'hF, 2'b00);
    rd(4'd4, v);
    check("R5 2-byte set ignored", v, 32'h0);
    cyc(1'b1, A_SET, 4'd8, 32'hF, 2'b00);
    rd(4'd4, v);
    check("R5 8-byte set ignored", v, 32'h0);
    check("R5 level stays low", {31'b0, seen_level}, 32'h0);
    cyc(1'b1, A_SET, 4'd4, 32'h3, 2'b00);
    cyc(1'b1, A_CLR, 4'd1, 32'h3, 2'b00);
    rd(4'd4, v);
    check("R5 1-byte clear ignored", v, 32'h3);
    rd(4'd2, v);
    check("R2 bad-size read all ones", v, 32'hFFFF_FFFF);
    cyc(1'b1, A_CLR, 4'd4, 32'h3, 2'b00);
  endtask

  task automatic t_hw();
    logic [31:0] v;
    cyc(1'b0, 8'h0, 4'd0, 32'h0, 2'b01);
    rd(4'd4, v);
    check("R6 source 0 mask", v, 32'h1);
    check("R8 level on hw raise", {31'b0, seen_level}, 32'h1);
    cyc(1'b1, A_CLR, 4'd4, 32'h1, 2'b00);
    cyc(1'b0, 8'h0, 4'd0, 32'h0, 2'b11);
    rd(4'd4, v);
    check("R6 both sources", v, 32'h101);
    // clear both bits while source 1 raises again
    cyc(1'b1, A_CLR, 4'd4, 32'h101, 2'b10);
    rd(4'd4, v);
    check("R7 raise beats clear", v, 32'h100);
    check("R7 level stays up", {31'b0, seen_level}, 32'h1);
    cyc(1'b1, A_CLR, 4'd4, 32'hFFFF_FFFF, 2'b00);
  endtask

  task automatic t_msg();
    logic [31:0] v;
    msi_enable = 1'b1;
    cyc(1'b1, A_SET, 4'd4, 32'h2, 2'b00);
    check("R9 pulse on set", {31'b0, seen_pulse}, 32'h1);
    check("R10 level low in msg mode", {31'b0, seen_level}, 32'h0);
    cyc(1'b0, 8'h0, 4'd0, 32'h0, 2'b00);
    check("R9 pulse one cycle", {31'b0, seen_pulse}, 32'h0);
    cyc(1'b1, A_SET, 4'd4, 32'h0, 2'b00);
    check("R9 pulse on zero set while pending", {31'b0, seen_pulse}, 32'h1);
    cyc(1'b1, A_CLR, 4'd4, 32'h2, 2'b00);
    check("R9 no pulse on clear", {31'b0, seen_pulse}, 32'h0);
    cyc(1'b1, A_SET, 4'd4, 32'h0, 2'b00);
    check("R9 no pulse when empty", {31'b0, seen_pulse}, 32'h0);
    cyc(1'b0, 8'h0, 4'd0, 32'h0, 2'b01);
    check("R9 pulse on hw raise", {31'b0, seen_pulse}, 32'h1);
    msi_enable = 1'b0;
    cyc(1'b0, 8'h0, 4'd0, 32'h0, 2'b00);
    cyc(1'b0, 8'h0, 4'd0, 32'h0, 2'b00);
    check("R10 level waits after mode switch", {31'b0, seen_level}, 32'h0);
    rd(4'd4, v);
    check("R10 bits still pending", v, 32'h1);
    cyc(1'b1, A_SET, 4'd4, 32'h0, 2'b00);
    check("R10 level on next raise", {31'b0, seen_level}, 32'h1);
    check("R9 no pulse in level mode", {31'b0, seen_pulse}, 32'h0);
    cyc(1'b1, A_CLR, 4'd4, 32'h1, 2'b00);
    check("R8 level drops", {31'b0, seen_level}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = 8'h0;
    bus_size = 4'd0; bus_wdata = 32'h0; hw_raise = 2'b00;
    hw_mask = {32'h0000_0100, 32'h0000_0001}; msi_enable = 1'b0;
    seen_pulse = 1'b0; seen_level = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_size();
    t_hw();
    t_msg();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule